// File: doc/BRIEF.md
# Serial Port Buffer Status Flags

This block keeps the buffer-state flags for one serial channel and owns the two one-byte data holding registers that sit between the software or DMA side and the bit shifters. A "transmit buffer empty" flag tells software or DMA when a new byte may be loaded for sending. A "receive buffer full" flag tells them that a received byte is waiting. An overrun flag records that a good frame arrived while the previous byte was still unread.

Software reaches the flags through a small register window. Reading a flag as 1 arms it. A later status write of 0 to that bit then clears it. A DMA access to the matching data register clears the flag directly. The transmit shifter asks for a byte with a load strobe. The receive shifter reports each finished frame with a done strobe that carries an error qualifier. Bit timing, framing and baud generation live elsewhere.

Top module: `sio_bufstat`

## Requirements
- R1: After reset the status register (address 0) reads 0x80: transmit-empty in bit 7 is 1, receive-full in bit 6 is 0, overrun in bit 5 is 0, and bits 4:0 are 0. Both data registers hold 0, and address 3 reads 0. `reg_rdata` shows the addressed register combinationally. Only the `reg_rd` strobe has side effects.
- R2: A status write of 0 to bit 7, 6 or 5 clears that flag only if a status read since the previous status write returned that bit as 1. Every status write disarms all flags. Writing 1 to a flag bit, and writing any value to bits 4:0, has no effect.
- R3: A DMA write stores its byte in the transmit register (address 1) and clears transmit-empty one cycle later. A CPU write to address 1 stores the byte but leaves the flag unchanged.
- R4: Transmit-empty is set by standby, by `tx_en` low, and by a shifter load request while the flag is 0. The load request is ignored while the flag is 1. The transmit register is presented on `txs_load_data` at all times.
- R5: A frame done with no error, with `rx_en` high and receive-full at 0, captures `rxs_data` into the receive register (address 2) and sets receive-full one cycle later.
- R6: A frame flagged as errored, or a frame arriving while `rx_en` is low, changes neither the receive register nor receive-full. Dropping `rx_en` does not change receive-full.
- R7: A good frame that arrives while receive-full is 1 sets overrun (bit 5). The new byte is discarded and the receive register keeps its old value.
- R8: Receive-full is cleared by a DMA read, by standby, and by the R2 software rule. A CPU read of address 2 returns the byte and does not clear the flag.
- R9: When a set and a clear condition for the same flag fall in one cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby entry: transmit-empty to 1, receive-full to 0 |
| tx_en | input | 1 | Transmitter enable; low holds transmit-empty at 1 |
| rx_en | input | 1 | Receiver enable; low ignores completed frames |
| reg_addr | input | 2 | Register select: 0 status, 1 transmit data, 2 receive data |
| reg_rd | input | 1 | CPU read strobe |
| reg_wr | input | 1 | CPU write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data for the addressed register |
| dma_tx_wr | input | 1 | DMA write strobe to the transmit register |
| dma_tx_data | input | 8 | DMA write data |
| dma_rx_rd | input | 1 | DMA read strobe from the receive register |
| dma_rx_data | output | 8 | Receive register contents |
| txs_load_req | input | 1 | Transmit shifter load request |
| txs_load_data | output | 8 | Transmit register contents |
| rxs_done | input | 1 | Receive shifter frame-complete strobe |
| rxs_err | input | 1 | Error qualifier for `rxs_done` |
| rxs_data | input | 8 | Byte from the receive shifter |
| tx_buf_empty | output | 1 | Transmit-empty flag |
| rx_buf_full | output | 1 | Receive-full flag |
| rx_overrun | output | 1 | Overrun flag |

## Verification
A wrong arm latch shows up on the next status write. The flag either fails to clear after a read as 1, or clears without a prior read. The status port shows this one cycle after the write. A wrong set/clear priority or a missed capture shows up in the status byte or on `dma_rx_data` in the cycle after the colliding strobes, so each check samples exactly one clock after its stimulus. Corruption of the receive register on errored or overrun frames is visible at `dma_rx_data` at once, with no other stimulus needed.

// File: rtl/sio_bufstat_pkg.sv
package sio_bufstat_pkg;

  localparam int STS_TXE_BIT = 7;
  localparam int STS_RXF_BIT = 6;
  localparam int STS_OVR_BIT = 5;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_TXBUF  = 2'd1,
    SEL_RXBUF  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // set dominates clear so that no event is dropped
  function automatic logic flag_next(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  function automatic logic [7:0] pack_status(logic txe, logic rxf, logic ovr);
    logic [7:0] s;
    s = '0;
    s[STS_TXE_BIT] = txe;
    s[STS_RXF_BIT] = rxf;
    s[STS_OVR_BIT] = ovr;
    return s;
  endfunction

endpackage

// File: rtl/sio_bufstat_flag.sv
module sio_bufstat_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_en,
  input  logic force_val,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic sts_rd,
  input  logic sts_wr,
  input  logic wr_bit,
  output logic flag_o
);
  import sio_bufstat_pkg::*;

  logic flag_q, armed_q;
  logic flag_d, armed_d, sw_clr;

  always_comb begin
    sw_clr = sts_wr & ~wr_bit & armed_q;
    if (force_en) flag_d = force_val;
    else          flag_d = flag_next(flag_q, set_i, sw_clr | hw_clr_i);
    if (force_en | sts_wr)    armed_d = 1'b0;
    else if (sts_rd & flag_q) armed_d = 1'b1;
    else                      armed_d = armed_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sio_bufstat_decode.sv
module sio_bufstat_decode #(
  parameter int ADDR_W = 2
) (
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output sio_bufstat_pkg::reg_sel_e sel,
  output logic              sts_rd,
  output logic              sts_wr,
  output logic              txb_wr
);
  import sio_bufstat_pkg::*;

  always_comb begin
    if (reg_addr == ADDR_W'(0))      sel = SEL_STATUS;
    else if (reg_addr == ADDR_W'(1)) sel = SEL_TXBUF;
    else if (reg_addr == ADDR_W'(2)) sel = SEL_RXBUF;
    else                             sel = SEL_NONE;
    sts_rd = reg_rd & (sel == SEL_STATUS);
    sts_wr = reg_wr & (sel == SEL_STATUS);
    txb_wr = reg_wr & (sel == SEL_TXBUF);
  end
endmodule

// File: rtl/sio_bufstat_txpath.sv
module sio_bufstat_txpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              tx_en,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              load_req,
  input  logic              sts_rd,
  input  logic              sts_wr,
  input  logic              wr_bit,
  output logic [DATA_W-1:0] tx_buf,
  output logic              tx_empty,
  output logic              load_fire
);
  logic [DATA_W-1:0] buf_q;

  assign load_fire = load_req & ~tx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)      buf_q <= '0;
    else if (dma_wr) buf_q <= dma_wdata;
    else if (cpu_wr) buf_q <= cpu_wdata;
  end

  sio_bufstat_flag #(.RST_VAL(1'b1)) u_txe (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_en (standby),
    .force_val(1'b1),
    .set_i    (load_fire | ~tx_en),
    .hw_clr_i (dma_wr),
    .sts_rd   (sts_rd),
    .sts_wr   (sts_wr),
    .wr_bit   (wr_bit),
    .flag_o   (tx_empty)
  );

  assign tx_buf = buf_q;
endmodule

// File: rtl/sio_bufstat_rxpath.sv
module sio_bufstat_rxpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              rx_en,
  input  logic              done,
  input  logic              err,
  input  logic [DATA_W-1:0] din,
  input  logic              dma_rd,
  input  logic              sts_rd,
  input  logic              sts_wr,
  input  logic              wr_full_bit,
  input  logic              wr_ovr_bit,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              accept,
  output logic              ovr_evt
);
  logic [DATA_W-1:0] buf_q;
  logic good;

  assign good    = done & ~err & rx_en;
  assign accept  = good & ~rx_full;
  assign ovr_evt = good & rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n)      buf_q <= '0;
    else if (accept) buf_q <= din;
  end

  sio_bufstat_flag #(.RST_VAL(1'b0)) u_rxf (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_en (standby),
    .force_val(1'b0),
    .set_i    (accept),
    .hw_clr_i (dma_rd),
    .sts_rd   (sts_rd),
    .sts_wr   (sts_wr),
    .wr_bit   (wr_full_bit),
    .flag_o   (rx_full)
  );

  sio_bufstat_flag #(.RST_VAL(1'b0)) u_ovr (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_en (1'b0),
    .force_val(1'b0),
    .set_i    (ovr_evt),
    .hw_clr_i (1'b0),
    .sts_rd   (sts_rd),
    .sts_wr   (sts_wr),
    .wr_bit   (wr_ovr_bit),
    .flag_o   (rx_ovr)
  );

  assign rx_buf = buf_q;
endmodule

// File: rtl/sio_bufstat.sv
module sio_bufstat #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_tx_wr,
  input  logic [DATA_W-1:0] dma_tx_data,
  input  logic              dma_rx_rd,
  output logic [DATA_W-1:0] dma_rx_data,
  input  logic              txs_load_req,
  output logic [DATA_W-1:0] txs_load_data,
  input  logic              rxs_done,
  input  logic              rxs_err,
  input  logic [DATA_W-1:0] rxs_data,
  output logic              tx_buf_empty,
  output logic              rx_buf_full,
  output logic              rx_overrun
);
  import sio_bufstat_pkg::*;

  reg_sel_e sel;
  logic sts_rd, sts_wr, txb_wr;
  logic tx_load_fire, rx_accept, rx_overrun_evt;
  logic [DATA_W-1:0] tx_buf, rx_buf;

  sio_bufstat_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_rd  (reg_rd),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .sel     (sel),
    .sts_rd  (sts_rd),
    .sts_wr  (sts_wr),
    .txb_wr  (txb_wr)
  );

  sio_bufstat_txpath #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .tx_en    (tx_en),
    .cpu_wr   (txb_wr),
    .cpu_wdata(reg_wdata),
    .dma_wr   (dma_tx_wr),
    .dma_wdata(dma_tx_data),
    .load_req (txs_load_req),
    .sts_rd   (sts_rd),
    .sts_wr   (sts_wr),
    .wr_bit   (reg_wdata[STS_TXE_BIT]),
    .tx_buf   (tx_buf),
    .tx_empty (tx_buf_empty),
    .load_fire(tx_load_fire)
  );

  sio_bufstat_rxpath #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .rx_en      (rx_en),
    .done       (rxs_done),
    .err        (rxs_err),
    .din        (rxs_data),
    .dma_rd     (dma_rx_rd),
    .sts_rd     (sts_rd),
    .sts_wr     (sts_wr),
    .wr_full_bit(reg_wdata[STS_RXF_BIT]),
    .wr_ovr_bit (reg_wdata[STS_OVR_BIT]),
    .rx_buf     (rx_buf),
    .rx_full    (rx_buf_full),
    .rx_ovr     (rx_overrun),
    .accept     (rx_accept),
    .ovr_evt    (rx_overrun_evt)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata = DATA_W'(pack_status(tx_buf_empty, rx_buf_full, rx_overrun));
      SEL_TXBUF:  reg_rdata = tx_buf;
      SEL_RXBUF:  reg_rdata = rx_buf;
      default:    reg_rdata = '0;
    endcase
  end

  assign dma_rx_data   = rx_buf;
  assign txs_load_data = tx_buf;
endmodule

// File: rtl/sio_bufstat_chk.sv
module sio_bufstat_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              rx_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dma_tx_wr,
  input logic              dma_rx_rd,
  input logic              rxs_done,
  input logic              rxs_err,
  input logic              tx_buf_empty,
  input logic              rx_buf_full,
  input logic              rx_overrun,
  input logic [DATA_W-1:0] dma_rx_data,
  input logic              tx_load_fire,
  input logic              rx_accept,
  input logic              rx_overrun_evt
);
  AST_LOAD_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_fire |=> tx_buf_empty); // R4
  AST_TXE_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_buf_empty) |-> $past(dma_tx_wr || (reg_wr && reg_addr == ADDR_W'(0) && !reg_wdata[7]))); // R3
  AST_STANDBY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (tx_buf_empty && !rx_buf_full)); // R8
  AST_RXBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_accept |=> $stable(dma_rx_data)); // R6
  AST_ERR_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rxs_done && rxs_err && !rx_buf_full) |-> !rx_accept); // R6
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_evt |=> (rx_overrun && $stable(dma_rx_data))); // R7
  AST_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && !standby) |=> rx_buf_full); // R5
  AST_RXEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rxs_done && !rx_en) |-> !(rx_accept || rx_overrun_evt)); // R6
  AST_FULL_DROP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_buf_full) |-> $past(dma_rx_rd || standby || reg_wr)); // R8
endmodule

bind sio_bufstat sio_bufstat_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .standby       (standby),
  .rx_en         (rx_en),
  .reg_addr      (reg_addr),
  .reg_wr        (reg_wr),
  .reg_wdata     (reg_wdata),
  .dma_tx_wr     (dma_tx_wr),
  .dma_rx_rd     (dma_rx_rd),
  .rxs_done      (rxs_done),
  .rxs_err       (rxs_err),
  .tx_buf_empty  (tx_buf_empty),
  .rx_buf_full   (rx_buf_full),
  .rx_overrun    (rx_overrun),
  .dma_rx_data   (dma_rx_data),
  .tx_load_fire  (tx_load_fire),
  .rx_accept     (rx_accept),
  .rx_overrun_evt(rx_overrun_evt)
);

// File: tb/sio_bufstat_tb.sv
module sio_bufstat_tb;
  logic clk = 1'b0;
  logic rst_n, standby, tx_en, rx_en, reg_rd, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, dma_tx_data, dma_rx_data, txs_load_data, rxs_data;
  logic dma_tx_wr, dma_rx_rd, txs_load_req, rxs_done, rxs_err;
  logic tx_buf_empty, rx_buf_full, rx_overrun;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sio_bufstat u_dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .tx_en(tx_en), .rx_en(rx_en),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_tx_wr(dma_tx_wr), .dma_tx_data(dma_tx_data),
    .dma_rx_rd(dma_rx_rd), .dma_rx_data(dma_rx_data), .txs_load_req(txs_load_req),
    .txs_load_data(txs_load_data), .rxs_done(rxs_done), .rxs_err(rxs_err),
    .rxs_data(rxs_data), .tx_buf_empty(tx_buf_empty), .rx_buf_full(rx_buf_full),
    .rx_overrun(rx_overrun)
  );

  // ops: 1 status read, 2 status write, 3 DMA tx write, 4 shifter load,
  // 5 good frame, 6 errored frame, 7 DMA rx read, 8 standby, 9 tx_en low
  // vector = {req, op, data, expected status, expected rx byte, expected tx byte}
  localparam int NV = 22;
  localparam logic [39:0] VEC [NV] = '{
    {4'd2, 4'd2, 8'h00, 8'h80, 8'h00, 8'h00}, // R2 write 0 unarmed
    {4'd2, 4'd1, 8'h00, 8'h80, 8'h00, 8'h00}, // R2 arm
    {4'd2, 4'd2, 8'hFF, 8'h80, 8'h00, 8'h00}, // R2 ones ignored, disarms
    {4'd2, 4'd2, 8'h00, 8'h80, 8'h00, 8'h00}, // R2 disarmed
    {4'd2, 4'd1, 8'h00, 8'h80, 8'h00, 8'h00}, // R2 arm
    {4'd2, 4'd2, 8'h00, 8'h00, 8'h00, 8'h00}, // R2 clear
    {4'd4, 4'd4, 8'h00, 8'h80, 8'h00, 8'h00}, // R4 load refills
    {4'd3, 4'd3, 8'hA5, 8'h00, 8'h00, 8'hA5}, // R3 DMA write
    {4'd4, 4'd4, 8'h00, 8'h80, 8'h00, 8'hA5}, // R4
    {4'd4, 4'd4, 8'h00, 8'h80, 8'h00, 8'hA5}, // R4 ignored when empty
    {4'd5, 4'd5, 8'h3C, 8'hC0, 8'h3C, 8'hA5}, // R5
    {4'd6, 4'd6, 8'h55, 8'hC0, 8'h3C, 8'hA5}, // R6 errored frame
    {4'd7, 4'd5, 8'h77, 8'hE0, 8'h3C, 8'hA5}, // R7 overrun
    {4'd8, 4'd7, 8'h00, 8'hA0, 8'h3C, 8'hA5}, // R8 DMA read
    {4'd5, 4'd5, 8'h11, 8'hE0, 8'h11, 8'hA5}, // R5
    {4'd2, 4'd1, 8'h00, 8'hE0, 8'h11, 8'hA5}, // R2 arm all
    {4'd8, 4'd2, 8'h80, 8'h80, 8'h11, 8'hA5}, // R8 sw clear rx, ovr
    {4'd3, 4'd3, 8'h0F, 8'h00, 8'h11, 8'h0F}, // R3
    {4'd4, 4'd9, 8'h00, 8'h80, 8'h11, 8'h0F}, // R4 tx_en low
    {4'd3, 4'd3, 8'h0E, 8'h00, 8'h11, 8'h0E}, // R3
    {4'd5, 4'd5, 8'h22, 8'h40, 8'h22, 8'h0E}, // R5
    {4'd8, 4'd8, 8'h00, 8'h80, 8'h22, 8'h0E}  // R8 standby
  };

  task automatic check(string what, int req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic set_op(int op, logic [7:0] d);
    case (op)
      1: begin reg_addr = 2'd0; reg_rd = 1'b1; end
      2: begin reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = d; end
      3: begin dma_tx_wr = 1'b1; dma_tx_data = d; end
      4: txs_load_req = 1'b1;
      5: begin rxs_done = 1'b1; rxs_data = d; end
      6: begin rxs_done = 1'b1; rxs_err = 1'b1; rxs_data = d; end
      7: dma_rx_rd = 1'b1;
      8: standby = 1'b1;
      9: tx_en = 1'b0;
      default: ;
    endcase
  endtask

  task automatic idle();
    reg_addr = 2'd0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    dma_tx_wr = 0; dma_tx_data = 0; dma_rx_rd = 0; txs_load_req = 0;
    rxs_done = 0; rxs_err = 0; rxs_data = 0; standby = 0; tx_en = 1; rx_en = 1;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic peek(int req, string what, logic [7:0] exp_sts);
    reg_addr = 2'd0;
    #1;
    check({what, " status"}, req, reg_rdata, exp_sts);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    peek(1, "reset", 8'h80);
    check("reset rx byte", 1, dma_rx_data, 8'h00);
    check("reset tx byte", 1, txs_load_data, 8'h00);
    check("reset overrun", 1, {7'd0, rx_overrun}, 8'h00);
    reg_addr = 2'd3; #1;
    check("addr 3 read", 1, reg_rdata, 8'h00);
    reg_addr = 2'd0;

    for (int i = 0; i < NV; i++) begin
      set_op(int'(VEC[i][35:32]), VEC[i][31:24]);
      tick();
      peek(int'(VEC[i][39:36]), $sformatf("vec %0d", i), VEC[i][23:16]);
      check($sformatf("vec %0d rx byte", i), int'(VEC[i][39:36]), dma_rx_data, VEC[i][15:8]);
      check($sformatf("vec %0d tx byte", i), int'(VEC[i][39:36]), txs_load_data, VEC[i][7:0]);
    end

    // R9 DMA write and tx_en low together: set wins
    set_op(3, 8'h99); set_op(9, 8'h00); tick();
    peek(9, "tx set beats clear", 8'h80);
    check("tx byte stored", 3, txs_load_data, 8'h99);

    // R6 frame with rx_en low is dropped
    set_op(5, 8'h5A); rx_en = 0; tick();
    peek(6, "frame rx_en low", 8'h80);
    check("rx byte rx_en low", 6, dma_rx_data, 8'h22);

    // R5 then R6: disabling the receiver keeps the full flag
    set_op(5, 8'h5B); tick();
    peek(5, "accept 5B", 8'hC0);
    rx_en = 0; tick();
    peek(6, "rx_en drop", 8'hC0);

    // R8 CPU read of receive register returns byte, flag stays
    reg_addr = 2'd2; reg_rd = 1; #1;
    check("cpu rx read data", 8, reg_rdata, 8'h5B);
    tick();
    peek(8, "after cpu rx read", 8'hC0);

    // R7 overrun, then R9 new overrun beats software clear
    set_op(5, 8'h6C); tick();
    peek(7, "overrun", 8'hE0);
    check("overrun keeps byte", 7, dma_rx_data, 8'h5B);
    set_op(1, 8'h00); tick();
    set_op(2, 8'hC0); set_op(5, 8'h7D); tick();
    peek(9, "ovr set beats clear", 8'hE0);
    set_op(1, 8'h00); tick();
    set_op(2, 8'h00); tick();
    peek(2, "clear all armed", 8'h00);

    // R3 CPU write of transmit register keeps flag
    reg_addr = 2'd1; reg_wr = 1; reg_wdata = 8'h42; tick();
    peek(3, "cpu tx write", 8'h00);
    check("cpu tx byte", 3, txs_load_data, 8'h42);
    reg_addr = 2'd1; #1;
    check("tx readback", 3, reg_rdata, 8'h42);
    reg_addr = 2'd0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule